// File: doc/BRIEF.md
# Micro-frame Index Counter with List-Size Rollover

This block keeps the running micro-frame index that a USB 2.0 host controller uses to walk its periodic schedule. Each 125 µs tick advances a 14-bit index by one while the controller is running. The low three bits count micro-frames inside a frame, and the upper bits select the entry in the frame list. Every advance raises a start-of-frame status flag that software can use as a time base.

The frame list size is programmable through a 3-bit code, from 1024 entries down to 8. A rollover flag is raised whenever an advance flips the one index bit that marks the end of the selected list. No compare against a wrap value is used. Both flags are cleared by writing a one to them. Each flag has its own interrupt enable. While the controller is halted the index holds its value, and only then may software load a new index.

Top module: `mfidx_unit`

## Requirements
- R1: After reset the index is 0, both status flags are 0, both interrupt enables are 0 and `irq` is 0.
- R2: While `run_en` is 1, each cycle with `mf_tick` high advances `frame_idx` by exactly one, visible after that clock edge. While `run_en` is 0, ticks change neither the index nor any flag.
- R3: Every advance sets `sof_flag` (status bit 0) on the following cycle.
- R4: On an advance, `roll_flag` (status bit 1) is set when index bit (13 − `size_code`) changes. Code 000 selects 1024 entries (bit 13), 001 selects 512 (bit 12), 010 selects 256, 011 selects 128, 100 selects 64, 101 selects 32, 110 selects 16, and 111 selects 8 (bit 6).
- R5: An advance that leaves the watched bit unchanged does not set `roll_flag`, even when a different index bit toggles.
- R6: A write to address 1 clears each status flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R7: When an advance sets a flag in the same cycle as a write-one-to-clear of that flag, the flag ends up set.
- R8: `halted` is always the inverse of `run_en`.
- R9: A write to address 0 loads `wr_data[13:0]` into the index only while `run_en` is 0. While running, the write is ignored.
- R10: Address 2 holds the interrupt enables (bit 0 for start-of-frame, bit 1 for rollover). `irq` is high exactly when some flag and its enable are both set.
- R11: The index wraps from 0x3FFF to 0, and with code 000 that wrap sets `roll_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mf_tick | input | 1 | One-cycle strobe per 125 µs micro-frame |
| run_en | input | 1 | Run (1) / stop (0) control |
| size_code | input | 3 | Frame list size code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 index, 1 status clear, 2 interrupt enables |
| wr_data | input | 16 | Write data |
| frame_idx | output | 14 | Current micro-frame index |
| sof_flag | output | 1 | Start-of-frame status flag |
| roll_flag | output | 1 | Frame-list rollover status flag |
| halted | output | 1 | Inverse of run/stop |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
A wrong index value shows on `frame_idx` one cycle after the tick or write that caused it. From then on it stays visible, because every later value is built on the wrong one. A watched-bit selector that picks the wrong bit only shows at a list boundary. For that reason the index is preloaded just below the wrap point for every size code, and also just below the next lower bit, so a missed or extra `roll_flag` appears on the cycle after the single tick. A flag register that drops a set or a clear shows on the flag output, and through `irq`, in the cycle after the conflicting write.

// File: rtl/mfidx_pkg.sv
// Shared constants and types for the micro-frame index unit.
// Assumes a register write port with a 2-bit address.
package mfidx_pkg;

    localparam int IDX_W     = 14;
    localparam int CODE_W    = 3;
    localparam int DATA_W    = 16;
    localparam int NUM_FLAGS = 2;
    localparam int FLAG_SOF  = 0;
    localparam int FLAG_ROLL = 1;

    typedef enum logic [1:0] {
        ADDR_IDX  = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_IEN  = 2'd2
    } reg_addr_e;

endpackage

// File: rtl/mfidx_sel.sv
// Watched-bit toggle detector.
// For each size code it checks whether index bit (IDX_W-1-code) differs
// between the current and the next index, then picks the result for the
// programmed code. Assumes IDX_W is at least 2**CODE_W.
module mfidx_sel #(
    parameter int IDX_W  = 14,
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] size_code,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [IDX_W-1:0]  nxt_idx,
    output logic              toggled
);

    localparam int NUM_CODES = 1 << CODE_W;

    logic [NUM_CODES-1:0] tog_by_code;

    // One toggle test per size code.
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
        localparam int BIT = IDX_W - 1 - c;
        assign tog_by_code[c] = cur_idx[BIT] ^ nxt_idx[BIT];
    end

    // Pick the toggle test that belongs to the programmed list size.
    always_comb begin
        toggled = tog_by_code[size_code];
    end

endmodule

// File: rtl/mfidx_count.sv
// Micro-frame index register.
// Advances by one on a tick while running. It accepts a software load only
// while halted. It reports an advance pulse, and a rollover event when the
// advance flips the list-size bit. Assumes a synchronous active-low reset.
module mfidx_count #(
    parameter int IDX_W  = 14,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mf_tick,
    input  logic              run_en,
    input  logic [CODE_W-1:0] size_code,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  idx_wdata,
    output logic [IDX_W-1:0]  idx,
    output logic              adv,
    output logic              roll_evt
);

    logic [IDX_W-1:0] idx_inc;
    logic             bit_tog;

    // Advance condition and incremented index.
    always_comb begin
        adv     = mf_tick & run_en;
        idx_inc = idx + IDX_W'(1);
    end

    mfidx_sel #(
        .IDX_W  (IDX_W),
        .CODE_W (CODE_W)
    ) u_sel (
        .size_code (size_code),
        .cur_idx   (idx),
        .nxt_idx   (idx_inc),
        .toggled   (bit_tog)
    );

    // A rollover counts only when an advance flips the watched bit.
    always_comb begin
        roll_evt = adv & bit_tog;
    end

    // Index register: advance while running, load only while halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (adv) begin
            idx <= idx_inc;
        end else if (idx_wr && !run_en) begin
            idx <= idx_wdata;
        end
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_tick && run_en) |=> (idx == $past(idx) + IDX_W'(1))); // R2

    AST_HOLD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !idx_wr) |=> $stable(idx)); // R2

    AST_NO_LOAD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !mf_tick) |=> $stable(idx)); // R9

endmodule

// File: rtl/mfidx_flags.sv
// Status flags with write-one-to-clear and per-flag interrupt enables.
// An event that sets a flag wins over a clear in the same cycle.
// Assumes set events arrive as single-cycle pulses.
module mfidx_flags #(
    parameter int NUM_FLAGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_evt,
    input  logic                 clr_wr,
    input  logic                 ien_wr,
    input  logic [NUM_FLAGS-1:0] wdata,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);

    logic [NUM_FLAGS-1:0] ien;
    logic [NUM_FLAGS-1:0] clr_req;

    // Per-flag clear request from a status write.
    always_comb begin
        clr_req = {NUM_FLAGS{clr_wr}} & wdata;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        // One status bit: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set_evt[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_req[i]) begin
                flags[i] <= 1'b0;
            end
        end

        AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flags[i]); // R7

        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[i] && !set_evt[i]) |=> !flags[i]); // R6

        AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(set_evt[i])); // R4
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (ien_wr) begin
            ien <= wdata;
        end
    end

    // Interrupt: any flag that is both set and enabled.
    always_comb begin
        irq = |(flags & ien);
    end

endmodule

// File: rtl/mfidx_unit.sv
// Top of the micro-frame index unit.
// Decodes the register write port, connects the index counter to the
// status flags, and drives the halted indication. Assumes mf_tick is a
// single-cycle strobe synchronous to clk.
module mfidx_unit
    import mfidx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mf_tick,
    input  logic              run_en,
    input  logic [CODE_W-1:0] size_code,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [IDX_W-1:0]  frame_idx,
    output logic              sof_flag,
    output logic              roll_flag,
    output logic              halted,
    output logic              irq
);

    logic                 idx_wr;
    logic                 stat_wr;
    logic                 ien_wr;
    logic                 adv;
    logic                 roll_evt;
    logic [NUM_FLAGS-1:0] set_evt;
    logic [NUM_FLAGS-1:0] flags;

    // Write address decode.
    always_comb begin
        idx_wr  = wr_en && (wr_addr == ADDR_IDX);
        stat_wr = wr_en && (wr_addr == ADDR_STAT);
        ien_wr  = wr_en && (wr_addr == ADDR_IEN);
    end

    mfidx_count #(
        .IDX_W  (IDX_W),
        .CODE_W (CODE_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .mf_tick   (mf_tick),
        .run_en    (run_en),
        .size_code (size_code),
        .idx_wr    (idx_wr),
        .idx_wdata (wr_data[IDX_W-1:0]),
        .idx       (frame_idx),
        .adv       (adv),
        .roll_evt  (roll_evt)
    );

    // Map counter events onto status flag positions.
    always_comb begin
        set_evt            = '0;
        set_evt[FLAG_SOF]  = adv;
        set_evt[FLAG_ROLL] = roll_evt;
    end

    mfidx_flags #(
        .NUM_FLAGS (NUM_FLAGS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr_wr  (stat_wr),
        .ien_wr  (ien_wr),
        .wdata   (wr_data[NUM_FLAGS-1:0]),
        .flags   (flags),
        .irq     (irq)
    );

    // Status outputs and halted indication.
    always_comb begin
        sof_flag  = flags[FLAG_SOF];
        roll_flag = flags[FLAG_ROLL];
        halted    = !run_en;
    end

    AST_SOF_EACH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_tick && run_en) |=> sof_flag); // R3

    AST_HALT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> ($stable(sof_flag) && $stable(roll_flag))); // R2

endmodule

// File: tb/mfidx_unit_tb.sv
module mfidx_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mf_tick = 1'b0;
    logic        run_en = 1'b0;
    logic [2:0]  size_code = 3'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [13:0] frame_idx;
    logic        sof_flag, roll_flag, halted, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mfidx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .mf_tick(mf_tick), .run_en(run_en),
        .size_code(size_code), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_idx(frame_idx), .sof_flag(sof_flag),
        .roll_flag(roll_flag), .halted(halted), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock cycle with the given stimulus; returns 2 ns after the edge.
    task automatic cyc(input bit tk, input bit we, input logic [1:0] a, input logic [15:0] d);
        mf_tick = tk; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        mf_tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic load_idx(input logic [13:0] v);
        run_en = 1'b0;
        cyc(0, 1, 2'd0, {2'b00, v});
        cyc(0, 1, 2'd1, 16'h0003);
    endtask

    task automatic t_reset();
        chk("R1", "idx", frame_idx, 0);
        chk("R1", "sof", sof_flag, 0);
        chk("R1", "roll", roll_flag, 0);
        chk("R1", "irq", irq, 0);
        chk("R8", "halted", halted, 1);
    endtask

    task automatic t_halt();
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
        chk("R2", "idx halted", frame_idx, 0);
        chk("R2", "sof halted", sof_flag, 0);
        run_en = 1'b1; #1;
        chk("R8", "halted running", halted, 0);
        run_en = 1'b0; #1;
        chk("R8", "halted stopped", halted, 1);
    endtask

    task automatic t_advance();
        load_idx(14'h0010);
        size_code = 3'd0; run_en = 1'b1;
        cyc(1, 0, 0, 0);
        chk("R2", "idx +1", frame_idx, 14'h0011);
        chk("R3", "sof after tick", sof_flag, 1);
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        chk("R2", "idx no tick", frame_idx, 14'h0011);
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
        chk("R2", "idx +3", frame_idx, 14'h0014);
        chk("R5", "no roll", roll_flag, 0);
    endtask

    task automatic t_sizes();
        for (int c = 0; c < 8; c++) begin
            int b = 13 - c;
            size_code = 3'(c);
            load_idx(14'((1 << b) - 1));
            run_en = 1'b1;
            cyc(1, 0, 0, 0);
            chk("R4", $sformatf("idx code %0d", c), frame_idx, 1 << b);
            chk("R4", $sformatf("roll code %0d", c), roll_flag, 1);
            load_idx(14'((1 << b) | 14'h0005));
            run_en = 1'b1;
            cyc(1, 0, 0, 0);
            chk("R5", $sformatf("no roll mid code %0d", c), roll_flag, 0);
            load_idx(14'((1 << (b - 1)) - 1));
            run_en = 1'b1;
            cyc(1, 0, 0, 0);
            chk("R5", $sformatf("no roll lower bit code %0d", c), roll_flag, 0);
        end
    endtask

    task automatic t_w1c();
        size_code = 3'd7;
        load_idx(14'h003F);
        run_en = 1'b1;
        cyc(1, 0, 0, 0);
        run_en = 1'b0;
        cyc(0, 1, 2'd1, 16'h0001);
        chk("R6", "sof cleared", sof_flag, 0);
        chk("R6", "roll kept", roll_flag, 1);
        cyc(0, 1, 2'd1, 16'h0000);
        chk("R6", "roll kept on zero", roll_flag, 1);
        cyc(0, 1, 2'd1, 16'h0002);
        chk("R6", "roll cleared", roll_flag, 0);
    endtask

    task automatic t_set_wins();
        size_code = 3'd7;
        load_idx(14'h007F);
        run_en = 1'b1;
        cyc(1, 1, 2'd1, 16'h0003);
        chk("R7", "sof set wins", sof_flag, 1);
        chk("R7", "roll set wins", roll_flag, 1);
        run_en = 1'b0;
    endtask

    task automatic t_irq();
        load_idx(14'h0000);
        cyc(0, 1, 2'd2, 16'h0001);
        chk("R10", "irq no flag", irq, 0);
        run_en = 1'b1; size_code = 3'd0;
        cyc(1, 0, 0, 0);
        run_en = 1'b0;
        chk("R10", "irq sof enabled", irq, 1);
        cyc(0, 1, 2'd2, 16'h0002);
        chk("R10", "irq sof masked", irq, 0);
        cyc(0, 1, 2'd1, 16'h0001);
        size_code = 3'd6;
        load_idx(14'h007F);
        run_en = 1'b1;
        cyc(1, 0, 0, 0);
        run_en = 1'b0;
        chk("R10", "irq roll enabled", irq, 1);
        cyc(0, 1, 2'd1, 16'h0002);
        chk("R10", "irq after clear", irq, 0);
        cyc(0, 1, 2'd2, 16'h0000);
    endtask

    task automatic t_wr_running();
        load_idx(14'h0100);
        run_en = 1'b1;
        cyc(0, 1, 2'd0, 16'h1234);
        chk("R9", "write ignored running", frame_idx, 14'h0100);
        run_en = 1'b0;
        cyc(0, 1, 2'd0, 16'h1234);
        chk("R9", "write taken halted", frame_idx, 14'h1234);
    endtask

    task automatic t_wrap();
        size_code = 3'd0;
        load_idx(14'h3FFF);
        run_en = 1'b1;
        cyc(1, 0, 0, 0);
        run_en = 1'b0;
        chk("R11", "wrap idx", frame_idx, 0);
        chk("R11", "wrap roll", roll_flag, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        t_reset();
        t_halt();
        t_advance();
        t_sizes();
        t_w1c();
        t_set_wins();
        t_irq();
        t_wr_running();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule